// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block decides, cycle by cycle, whether the decoded instruction at the head of a single-issue, in-order pipeline may dispatch. The instruction names one of four execution unit classes (integer, add, multiply, divide), a destination register and up to two source registers. The block holds one busy flag per unit class and one pending-write flag per architectural register. It raises `stall` when the target unit is occupied, when a source register still awaits a result (read-after-write), or when the destination register still awaits a result (write-after-write). Write-after-read needs no check, because an older instruction in an in-order machine has always read its operands before a younger one can dispatch.

When an instruction dispatches, the block marks its unit busy and its destination pending. A result writeback clears the flag of the written register, and a per-unit completion strobe clears the busy flag of that unit. The decision uses only the registered flags. A writeback or completion that arrives in the same cycle as a request does not release that request until the next cycle.

Top module: `inorder_scoreboard`

## Requirements
- R1: After reset all unit busy flags and all register pending flags read zero.
- R2: A valid request whose unit class is marked busy is stalled. Unit codes: 0 integer, 1 add, 2 multiply, 3 divide. Bit n of `unit_busy` belongs to unit code n.
- R3: A valid request is stalled when a used source register (operand A or B) has its pending flag set.
- R4: A valid request is stalled when its destination register has its pending flag set.
- R5: Apart from R2, R3 and R4 nothing stalls a valid request. In particular, writing a register that an earlier dispatched instruction reads (a write-after-read pair) does not stall.
- R6: A dispatch sets the destination's bit in `reg_pending` (bit n for register n) and the unit's bit in `unit_busy`, both visible on the next cycle.
- R7: A writeback clears the register's pending flag on the next cycle. If a dispatch names the same register as destination in that cycle, the flag stays set.
- R8: A completion strobe for a unit clears its busy flag on the next cycle. If a dispatch to that unit happens in that cycle, the flag stays set.
- R9: A source whose use flag is low is never checked for a hazard.
- R10: `dispatch` is high exactly when `iss_valid` is high and `stall` is low. Without dispatch, no flag is set.
- R11: Hazard decisions use the flags as registered at the start of the cycle. A writeback or completion in the same cycle does not remove that cycle's stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A decoded instruction is presented |
| iss_unit | input | 2 | Unit class code |
| iss_dst | input | REG_W | Destination register |
| iss_src_a_use | input | 1 | Operand A is read |
| iss_src_a | input | REG_W | Operand A register |
| iss_src_b_use | input | 1 | Operand B is read |
| iss_src_b | input | REG_W | Operand B register |
| wb_valid | input | 1 | A result is written back this cycle |
| wb_reg | input | REG_W | Register being written back |
| unit_done | input | NUM_UNITS | Per-unit completion / ready strobe |
| stall | output | 1 | Request must wait |
| dispatch | output | 1 | Request leaves this cycle |
| unit_busy | output | NUM_UNITS | Registered unit busy flags |
| reg_pending | output | NUM_REGS | Registered register pending flags |

## Verification
Two events can land on the same flag in one cycle: a dispatch that sets a flag, and a writeback or unit completion that clears it. The bench provokes this in two ways. It dispatches to the divide unit with the divide completion strobe raised. In the same cycle it writes back the very register named as the new destination. Both flags must read set on the following cycle. A separate vector presents a request that is blocked by a pending source while that source is written back. The bench expects the stall in that cycle and the cleared flag one cycle later.

// File: rtl/inorder_scoreboard.sv
module inorder_scoreboard #(
  parameter int NUM_REGS  = 32,
  parameter int NUM_UNITS = 4,
  localparam int REG_W  = $clog2(NUM_REGS),
  localparam int UNIT_W = $clog2(NUM_UNITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_valid,
  input  logic [UNIT_W-1:0]    iss_unit,
  input  logic [REG_W-1:0]     iss_dst,
  input  logic                 iss_src_a_use,
  input  logic [REG_W-1:0]     iss_src_a,
  input  logic                 iss_src_b_use,
  input  logic [REG_W-1:0]     iss_src_b,
  input  logic                 wb_valid,
  input  logic [REG_W-1:0]     wb_reg,
  input  logic [NUM_UNITS-1:0] unit_done,
  output logic                 stall,
  output logic                 dispatch,
  output logic [NUM_UNITS-1:0] unit_busy,
  output logic [NUM_REGS-1:0]  reg_pending
);

  logic unit_hit, raw_a, raw_b, waw;
  logic [NUM_REGS-1:0]  pend_set, pend_clr;
  logic [NUM_UNITS-1:0] busy_set;

  assign unit_hit = unit_busy[iss_unit];
  assign raw_a    = iss_src_a_use & reg_pending[iss_src_a];
  assign raw_b    = iss_src_b_use & reg_pending[iss_src_b];
  assign waw      = reg_pending[iss_dst];

  assign stall    = iss_valid & (unit_hit | raw_a | raw_b | waw);
  assign dispatch = iss_valid & ~stall;

  assign pend_set = dispatch ? (NUM_REGS'(1) << iss_dst) : '0;
  assign pend_clr = wb_valid ? (NUM_REGS'(1) << wb_reg) : '0;
  assign busy_set = dispatch ? (NUM_UNITS'(1) << iss_unit) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unit_busy   <= '0;
      reg_pending <= '0;
    end else begin
      unit_busy   <= (unit_busy & ~unit_done) | busy_set;
      reg_pending <= (reg_pending & ~pend_clr) | pend_set;
    end
  end

endmodule

// File: rtl/inorder_scoreboard_chk.sv
module inorder_scoreboard_chk #(
  parameter int NUM_REGS  = 32,
  parameter int NUM_UNITS = 4,
  localparam int REG_W  = $clog2(NUM_REGS),
  localparam int UNIT_W = $clog2(NUM_UNITS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 iss_valid,
  input logic [UNIT_W-1:0]    iss_unit,
  input logic [REG_W-1:0]     iss_dst,
  input logic                 iss_src_a_use,
  input logic [REG_W-1:0]     iss_src_a,
  input logic                 iss_src_b_use,
  input logic [REG_W-1:0]     iss_src_b,
  input logic                 wb_valid,
  input logic [REG_W-1:0]     wb_reg,
  input logic [NUM_UNITS-1:0] unit_done,
  input logic                 stall,
  input logic                 dispatch,
  input logic [NUM_UNITS-1:0] unit_busy,
  input logic [NUM_REGS-1:0]  reg_pending
);

  p_busy_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && unit_busy[iss_unit] |-> stall);

  p_raw_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_src_a_use && reg_pending[iss_src_a] |-> stall);

  p_raw_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_src_b_use && reg_pending[iss_src_b] |-> stall);

  p_waw_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && reg_pending[iss_dst] |-> stall);

  p_no_war_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !unit_busy[iss_unit] && !reg_pending[iss_dst]
    && !(iss_src_a_use && reg_pending[iss_src_a])
    && !(iss_src_b_use && reg_pending[iss_src_b]) |-> !stall);

  p_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |=> reg_pending[$past(iss_dst)] && unit_busy[$past(iss_unit)]);

  p_wb_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !(dispatch && iss_dst == wb_reg) |=> !reg_pending[$past(wb_reg)]);

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_done
    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      unit_done[g] && !(dispatch && iss_unit == UNIT_W'(g)) |=> !unit_busy[g]);
  end

  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dispatch |-> iss_valid && !stall);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !stall && !dispatch);

endmodule

bind inorder_scoreboard inorder_scoreboard_chk #(
  .NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS)
) u_chk (.*);

// File: tb/inorder_scoreboard_tb.sv
`timescale 1ns/1ps
module inorder_scoreboard_tb;
  localparam int NR = 32;
  localparam int NU = 4;
  localparam int NV = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic iss_valid = 0, iss_src_a_use = 0, iss_src_b_use = 0, wb_valid = 0;
  logic [1:0] iss_unit = 0;
  logic [4:0] iss_dst = 0, iss_src_a = 0, iss_src_b = 0, wb_reg = 0;
  logic [NU-1:0] unit_done = 0;
  logic stall, dispatch;
  logic [NU-1:0] unit_busy;
  logic [NR-1:0] reg_pending;

  int checks = 0, fails = 0;
  logic [NU-1:0] m_busy = '0;
  logic [NR-1:0] m_pend = '0;

  always #2.5 clk = ~clk;

  inorder_scoreboard #(.NUM_REGS(NR), .NUM_UNITS(NU)) u_dut (.*);

  // {valid, unit, dst, a_use, a, b_use, b, wb_v, wb_reg, done, exp_stall}
  localparam logic [35:0] VEC [NV] = '{
    {1'b1, 2'd2, 5'd3, 1'b1, 5'd1, 1'b1, 5'd2, 1'b0, 5'd0, 4'b0000, 1'b0},
    {1'b1, 2'd1, 5'd4, 1'b1, 5'd3, 1'b0, 5'd0, 1'b0, 5'd0, 4'b0000, 1'b1},
    {1'b1, 2'd1, 5'd4, 1'b1, 5'd1, 1'b1, 5'd3, 1'b0, 5'd0, 4'b0000, 1'b1},
    {1'b1, 2'd1, 5'd4, 1'b0, 5'd3, 1'b1, 5'd1, 1'b0, 5'd0, 4'b0000, 1'b0},
    {1'b1, 2'd2, 5'd5, 1'b1, 5'd1, 1'b1, 5'd2, 1'b0, 5'd0, 4'b0000, 1'b1},
    {1'b1, 2'd0, 5'd3, 1'b1, 5'd1, 1'b0, 5'd0, 1'b0, 5'd0, 4'b0000, 1'b1},
    {1'b1, 2'd0, 5'd1, 1'b1, 5'd2, 1'b1, 5'd6, 1'b0, 5'd0, 4'b0000, 1'b0},
    {1'b0, 2'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd3, 4'b0100, 1'b0},
    {1'b1, 2'd2, 5'd3, 1'b1, 5'd2, 1'b0, 5'd0, 1'b0, 5'd0, 4'b0000, 1'b0},
    {1'b1, 2'd3, 5'd7, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 5'd7, 4'b1000, 1'b0},
    {1'b0, 2'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd1, 4'b1111, 1'b0},
    {1'b1, 2'd0, 5'd8, 1'b1, 5'd4, 1'b1, 5'd9, 1'b1, 5'd4, 4'b0000, 1'b1}
  };

  function automatic string tag(int i);
    case (i)
      0: return "R6 first dispatch";
      1: return "R3 operand A pending";
      2: return "R3 operand B pending";
      3: return "R9 unused source ignored";
      4: return "R2 unit busy";
      5: return "R4 destination pending";
      6: return "R5 write-after-read allowed";
      7: return "R7/R8 writeback and done idle";
      8: return "R10 dispatch after release";
      9: return "R7/R8 same-cycle set wins";
      10: return "R8 all units done";
      default: return "R11 same-cycle writeback no bypass";
    endcase
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic apply(input logic [35:0] v, input string t);
    logic es, md;
    @(negedge clk);
    {iss_valid, iss_unit, iss_dst, iss_src_a_use, iss_src_a, iss_src_b_use,
     iss_src_b, wb_valid, wb_reg, unit_done, es} = v;
    #1;
    chk(stall === es, {t, " stall"}, 64'(stall), 64'(es));
    md = iss_valid && !es;
    chk(dispatch === md, {t, " dispatch R10"}, 64'(dispatch), 64'(md));
    m_busy = (m_busy & ~unit_done) | (md ? (NU'(1) << iss_unit) : '0);
    m_pend = (m_pend & ~(wb_valid ? (NR'(1) << wb_reg) : '0)) | (md ? (NR'(1) << iss_dst) : '0);
    @(posedge clk);
    #1;
    chk(unit_busy === m_busy, {t, " unit_busy"}, 64'(unit_busy), 64'(m_busy));
    chk(reg_pending === m_pend, {t, " reg_pending"}, 64'(reg_pending), 64'(m_pend));
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(unit_busy === '0, "R1 busy after reset", 64'(unit_busy), 0);
    chk(reg_pending === '0, "R1 pending after reset", 64'(reg_pending), 0);
    for (int i = 0; i < NV; i++) apply(VEC[i], tag(i));

    // R1: reset in the middle of activity clears everything
    @(negedge clk);
    iss_valid = 0; wb_valid = 0; unit_done = '0;
    rst_n = 0;
    @(posedge clk);
    #1;
    chk(unit_busy === '0, "R1 busy after mid-run reset", 64'(unit_busy), 0);
    chk(reg_pending === '0, "R1 pending after mid-run reset", 64'(reg_pending), 0);
    @(negedge clk);
    rst_n = 1;
    m_busy = '0;
    m_pend = '0;

    // R4/R6: highest register and self-referencing operand
    apply({1'b1, 2'd3, 5'd31, 1'b1, 5'd31, 1'b0, 5'd0, 1'b0, 5'd0, 4'b0000, 1'b0}, "R6 top register");
    apply({1'b1, 2'd0, 5'd31, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 4'b0000, 1'b1}, "R4 top register pending");
    apply({1'b1, 2'd0, 5'd2, 1'b1, 5'd31, 1'b0, 5'd0, 1'b1, 5'd31, 4'b0000, 1'b1}, "R11 blocked while written back");
    apply({1'b1, 2'd0, 5'd2, 1'b1, 5'd31, 1'b0, 5'd0, 1'b0, 5'd0, 4'b0000, 1'b0}, "R7 released next cycle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule